// File: doc/BRIEF.md
# Pipelined Five-Lane Sorter

This block takes five unsigned words on every clock cycle and returns the same five words in sorted order on five output ports. Its core is a fixed compare-and-exchange network of nine comparators. The network is cut into two registered stages, so every input set leaves the block exactly two cycles after it entered. No handshake is involved. A caller that presents one set per cycle gets one sorted set per cycle, in the same sequence.

The data width is a parameter. A second parameter selects whether the `rst` input clears the pipeline synchronously or has no effect. The outputs come straight from the final register, so no combinational path runs from any input pin to any output pin. Before the pipeline has filled after start-up, the outputs hold no meaningful result.

Top module: `sort5_pipe`

## Requirements
- R1: `out1` carries the largest of the five values sampled from `in1`..`in5` and `out5` the smallest, so `out1 >= out2 >= out3 >= out4 >= out5` holds for every result.
- R2: Each result holds the same multiset as its input set. Repeated values all appear, as often as they were supplied.
- R3: A set held on the inputs during cycle t appears on the outputs during cycle t+2 (two rising edges later) and stays there for one full cycle.
- R4: A different set may be applied in every cycle. The results follow in the same sequence with no gap, one per cycle.
- R5: A change on the inputs between two rising edges leaves the outputs unchanged until the next rising edge.
- R6: With `RESET_EN` = 1, every rising edge that sees `rst` high clears both pipeline stages, so all five outputs read zero after it.
- R7: After `rst` falls, the outputs stay zero for the first two cycles. The first set applied in the cycle of release then appears two cycles later, so reset does not change the latency.
- R8: With `RESET_EN` = 0, `rst` is ignored and sorting continues at full rate while it is high.
- R9: Comparison is unsigned. A word with its top bit set ranks above every word whose top bit is clear (for example 0x80 above 0x7F).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear, honoured only when `RESET_EN` = 1 |
| in1 | input | DATA_W | Unsorted value, lane 1 |
| in2 | input | DATA_W | Unsorted value, lane 2 |
| in3 | input | DATA_W | Unsorted value, lane 3 |
| in4 | input | DATA_W | Unsorted value, lane 4 |
| in5 | input | DATA_W | Unsorted value, lane 5 |
| out1 | output | DATA_W | Largest value of the set |
| out2 | output | DATA_W | Second largest value |
| out3 | output | DATA_W | Median value |
| out4 | output | DATA_W | Second smallest value |
| out5 | output | DATA_W | Smallest value of the set |

## Verification
The bench builds two copies of the block. The first uses an 8-bit width with the clear enabled. It receives a table of corner vectors (ties, sorted and reversed orders, top-bit values), a long random stream, and clear windows both at start-up and in the middle of a stream, which test the zero outputs and the unchanged latency after release. The second uses a 3-bit width with the clear disabled. At that width all 32768 input combinations fit in one pass, so every pattern of ties and orderings is fed through the network. The whole pass runs with `rst` held high, which shows that this copy ignores it.

// File: rtl/sort5_pkg.sv
package sort5_pkg;

    // number of data lanes handled by the network
    localparam int unsigned LANES    = 5;
    // comparators in the whole network and how many sit before the first register
    localparam int unsigned CE_TOTAL = 9;
    localparam int unsigned CE_SPLIT = 6;

    // comparator k orders lanes CE_LO[k] (receives the minimum) and CE_HI[k]
    // (receives the maximum); entries are listed level by level:
    // level 1: k0,k1  level 2: k2,k3  level 3: k4,k5  level 4: k6,k7  level 5: k8
    localparam int unsigned CE_LO [CE_TOTAL] = '{0, 1, 0, 1, 0, 2, 1, 3, 2};
    localparam int unsigned CE_HI [CE_TOTAL] = '{3, 4, 2, 3, 1, 4, 2, 4, 3};

endpackage

// File: rtl/sort5_cmp.sv
module sort5_cmp #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o
);

    // unsigned compare-and-exchange; ties keep the operands in place
    always_comb begin
        if (b_i < a_i) begin
            lo_o = b_i;
            hi_o = a_i;
        end else begin
            lo_o = a_i;
            hi_o = b_i;
        end
    end

endmodule

// File: rtl/sort5_stage.sv
module sort5_stage
    import sort5_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned FIRST    = 0,
    parameter int unsigned COUNT    = CE_SPLIT,
    parameter bit          RESET_EN = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [LANES-1:0][DATA_W-1:0]   lanes_i,
    output logic [LANES-1:0][DATA_W-1:0]   lanes_o
);

    typedef logic [LANES-1:0][DATA_W-1:0] vec_t;

    typedef struct packed {
        vec_t lanes;
    } stage_t;

    vec_t   net [COUNT+1];
    stage_t stage_d;
    stage_t stage_q;

    assign net[0] = lanes_i;

    // chain of comparators taken from the shared network table
    for (genvar k = 0; k < COUNT; k++) begin : g_ce
        localparam int unsigned LO = CE_LO[FIRST+k];
        localparam int unsigned HI = CE_HI[FIRST+k];

        logic [DATA_W-1:0] mn;
        logic [DATA_W-1:0] mx;
        vec_t              nxt;

        sort5_cmp #(
            .DATA_W (DATA_W)
        ) u_ce (
            .a_i  (net[k][LO]),
            .b_i  (net[k][HI]),
            .lo_o (mn),
            .hi_o (mx)
        );

        always_comb begin
            nxt     = net[k];
            nxt[LO] = mn;
            nxt[HI] = mx;
        end

        assign net[k+1] = nxt;
    end

    always_comb begin
        stage_d.lanes = net[COUNT];
        if (RESET_EN && rst) begin
            stage_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

    assign lanes_o = stage_q.lanes;

    // R6
    stage_clear_chk: assert property (@(posedge clk)
        (RESET_EN && rst) |=> (lanes_o == '0));

endmodule

// File: rtl/sort5_pipe.sv
module sort5_pipe
    import sort5_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter bit          RESET_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in1,
    input  logic [DATA_W-1:0] in2,
    input  logic [DATA_W-1:0] in3,
    input  logic [DATA_W-1:0] in4,
    input  logic [DATA_W-1:0] in5,
    output logic [DATA_W-1:0] out1,
    output logic [DATA_W-1:0] out2,
    output logic [DATA_W-1:0] out3,
    output logic [DATA_W-1:0] out4,
    output logic [DATA_W-1:0] out5
);

    localparam int unsigned LATE_CNT = CE_TOTAL - CE_SPLIT;
    localparam int unsigned SUM_W    = DATA_W + 3;

    typedef logic [LANES-1:0][DATA_W-1:0] vec_t;

    vec_t in_vec;
    vec_t mid_vec;
    vec_t fin_vec;

    // lane 0 is in1; after sorting lane 0 holds the minimum
    assign in_vec = {in5, in4, in3, in2, in1};

    sort5_stage #(
        .DATA_W   (DATA_W),
        .FIRST    (0),
        .COUNT    (CE_SPLIT),
        .RESET_EN (RESET_EN)
    ) u_early (
        .clk     (clk),
        .rst     (rst),
        .lanes_i (in_vec),
        .lanes_o (mid_vec)
    );

    sort5_stage #(
        .DATA_W   (DATA_W),
        .FIRST    (CE_SPLIT),
        .COUNT    (LATE_CNT),
        .RESET_EN (RESET_EN)
    ) u_late (
        .clk     (clk),
        .rst     (rst),
        .lanes_i (mid_vec),
        .lanes_o (fin_vec)
    );

    // largest value leaves on out1, smallest on out5
    assign out1 = fin_vec[4];
    assign out2 = fin_vec[3];
    assign out3 = fin_vec[2];
    assign out4 = fin_vec[1];
    assign out5 = fin_vec[0];

    // ---------------- checks ----------------
    logic              rst_eff;
    logic [SUM_W-1:0]  sum_in;
    logic [SUM_W-1:0]  sum_out;
    logic [DATA_W-1:0] max_in;
    logic [DATA_W-1:0] min_in;

    assign rst_eff = RESET_EN && rst;

    always_comb begin
        sum_in  = '0;
        sum_out = SUM_W'(out1) + SUM_W'(out2) + SUM_W'(out3) + SUM_W'(out4) + SUM_W'(out5);
        max_in  = in1;
        min_in  = in1;
        for (int i = 0; i < LANES; i++) begin
            sum_in = sum_in + SUM_W'(in_vec[i]);
            if (in_vec[i] > max_in) max_in = in_vec[i];
            if (in_vec[i] < min_in) min_in = in_vec[i];
        end
    end

    // R1
    order_out_chk: assert property (@(posedge clk) disable iff (rst_eff)
        1'b1 |=> ##1 ((out1 >= out2) && (out2 >= out3) && (out3 >= out4) && (out4 >= out5)));

    // R1
    early_min_chk: assert property (@(posedge clk) disable iff (rst_eff)
        1'b1 |=> ((mid_vec[0] <= mid_vec[1]) && (mid_vec[0] <= mid_vec[2]) &&
                  (mid_vec[0] <= mid_vec[3]) && (mid_vec[0] <= mid_vec[4])));

    // R2
    sum_keep_chk: assert property (@(posedge clk) disable iff (rst_eff)
        1'b1 |=> ##1 (sum_out == $past(sum_in, 2)));

    // R2
    extreme_keep_chk: assert property (@(posedge clk) disable iff (rst_eff)
        1'b1 |=> ##1 ((out1 == $past(max_in, 2)) && (out5 == $past(min_in, 2))));

    // R7
    release_zero_chk: assert property (@(posedge clk)
        $fell(rst_eff) |=> ((out1 == '0) && (out5 == '0)));

endmodule

// File: tb/sort5_pipe_tb.sv
module sort5_pipe_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst;
    logic [7:0] w_in1, w_in2, w_in3, w_in4, w_in5;
    logic [7:0] w_out1, w_out2, w_out3, w_out4, w_out5;
    logic [2:0] n_in1, n_in2, n_in3, n_in4, n_in5;
    logic [2:0] n_out1, n_out2, n_out3, n_out4, n_out5;

    sort5_pipe #(.DATA_W(8), .RESET_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst),
        .in1(w_in1), .in2(w_in2), .in3(w_in3), .in4(w_in4), .in5(w_in5),
        .out1(w_out1), .out2(w_out2), .out3(w_out3), .out4(w_out4), .out5(w_out5)
    );

    sort5_pipe #(.DATA_W(3), .RESET_EN(1'b0)) u_dut_nr (
        .clk(clk), .rst(rst),
        .in1(n_in1), .in2(n_in2), .in3(n_in3), .in4(n_in4), .in5(n_in5),
        .out1(n_out1), .out2(n_out2), .out3(n_out3), .out4(n_out4), .out5(n_out5)
    );

    // {in1,in2,in3,in4,in5, out1,out2,out3,out4,out5}
    localparam int VEC_N = 12;
    localparam logic [79:0] VEC [VEC_N] = '{
        80'h05_03_09_01_07_09_07_05_03_01,
        80'h2A_2A_2A_2A_2A_2A_2A_2A_2A_2A,
        80'h01_02_03_04_05_05_04_03_02_01,
        80'h05_04_03_02_01_05_04_03_02_01,
        80'h00_FF_00_FF_80_FF_FF_80_00_00,
        80'h7F_80_01_FE_00_FE_80_7F_01_00,
        80'h10_10_20_20_10_20_20_10_10_10,
        80'hFF_FF_FF_FF_FF_FF_FF_FF_FF_FF,
        80'h00_00_00_00_00_00_00_00_00_00,
        80'hC3_3C_5A_A5_66_C3_A5_66_5A_3C,
        80'h01_00_00_00_00_01_00_00_00_00,
        80'h00_00_00_00_01_01_00_00_00_00
    };

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [39:0] w_exp_a, w_exp_b;
    logic [39:0] n_exp_a, n_exp_b;
    int          w_fill, n_fill;

    function automatic logic [39:0] ref_sort(input logic [39:0] ins);
        logic [7:0] v [5];
        logic [7:0] t;
        for (int i = 0; i < 5; i++) v[i] = ins[39-8*i -: 8];
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 4 - p; i++) begin
                if (v[i] > v[i+1]) begin
                    t = v[i]; v[i] = v[i+1]; v[i+1] = t;
                end
            end
        end
        return {v[4], v[3], v[2], v[1], v[0]};
    endfunction

    function automatic logic [39:0] w_outs();
        return {w_out1, w_out2, w_out3, w_out4, w_out5};
    endfunction

    function automatic logic [39:0] n_outs();
        return {5'd0, n_out1, 5'd0, n_out2, 5'd0, n_out3, 5'd0, n_out4, 5'd0, n_out5};
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of the wide stream: check the set applied two cycles ago, then apply a new one
    task automatic step_w(input logic [39:0] ins, input logic [39:0] exp, input string req, input bit hold);
        logic [39:0] seen;
        @(negedge clk);
        if (w_fill >= 2) chk(req, w_outs(), w_exp_b);
        seen    = w_outs();
        w_exp_b = w_exp_a;
        w_exp_a = exp;
        {w_in1, w_in2, w_in3, w_in4, w_in5} = ins;
        w_fill++;
        if (hold) begin
            #1;
            chk("R5 outputs moved between edges", w_outs(), seen);
        end
    endtask

    task automatic step_n(input logic [14:0] v, input string req);
        logic [39:0] ins;
        @(negedge clk);
        if (n_fill >= 2) chk(req, n_outs(), n_exp_b);
        ins = {5'd0, v[14:12], 5'd0, v[11:9], 5'd0, v[8:6], 5'd0, v[5:3], 5'd0, v[2:0]};
        n_exp_b = n_exp_a;
        n_exp_a = ref_sort(ins);
        {n_in1, n_in2, n_in3, n_in4, n_in5} = v;
        n_fill++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [39:0] rv;
        rst = 1'b1;
        {w_in1, w_in2, w_in3, w_in4, w_in5} = '0;
        {n_in1, n_in2, n_in3, n_in4, n_in5} = '0;
        w_exp_a = '0; w_exp_b = '0; n_exp_a = '0; n_exp_b = '0;
        w_fill = 0; n_fill = 0;

        // R6: cleared under reset from start-up
        repeat (3) @(negedge clk);
        chk("R6 reset state", w_outs(), 40'd0);

        // table walk, one set per cycle (R1 R2 R3 R4 R9)
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < VEC_N; i++) begin
            step_w(VEC[i][79:40], VEC[i][39:0], "R1 R2 R3 R9 table", (i == 5));
        end
        step_w(40'd0, 40'd0, "R3 R4 table drain", 1'b0);
        step_w(40'd0, 40'd0, "R3 R4 table drain", 1'b0);

        // random stream (R1 R2 R4)
        for (int i = 0; i < 300; i++) begin
            rv = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
            step_w(rv, ref_sort(rv), "R1 R2 R4 random", 1'b0);
        end
        step_w(40'hA0_0B_A0_0B_01, ref_sort(40'hA0_0B_A0_0B_01), "R2 random drain", 1'b0);
        step_w(40'd0, 40'd0, "R2 random drain", 1'b0);

        // mid-stream clear; narrow copy ignores rst (R8) and is enumerated fully
        @(negedge clk);
        rst = 1'b1;
        {w_in1, w_in2, w_in3, w_in4, w_in5} = 40'h11_22_33_44_55;
        repeat (2) @(negedge clk);
        chk("R6 clear mid-stream", w_outs(), 40'd0);
        for (int v = 0; v < 32768; v++) begin
            logic [14:0] vv;
            vv = v[14:0];
            step_n(vv, "R8 R1 R2 exhaustive narrow with rst high");
        end
        step_n(15'd0, "R8 narrow drain");
        step_n(15'd0, "R8 narrow drain");
        chk("R6 held clear", w_outs(), 40'd0);

        // release: two zero cycles, then the first set (R7)
        @(negedge clk);
        rst     = 1'b0;
        w_exp_a = '0;
        w_exp_b = '0;
        w_fill  = 2;
        {w_in1, w_in2, w_in3, w_in4, w_in5} = 40'h09_80_7F_00_42;
        w_exp_b = w_exp_a;
        w_exp_a = 40'h80_7F_42_09_00;
        step_w(40'h33_33_01_33_02, ref_sort(40'h33_33_01_33_02), "R7 zero after release", 1'b0);
        step_w(40'd0, 40'd0, "R7 first set after release", 1'b0);
        step_w(40'd0, 40'd0, "R7 second set after release", 1'b0);
        step_w(40'd0, 40'd0, "R7 drain", 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule